// File: doc/BRIEF.md
# Eight-Channel PCM Sample Mixer

This block is a time-shared playback engine for eight sampled voices. Once per output period it walks the voices in a fixed order. For each enabled voice it fetches one byte from an external wave memory at the voice's fixed-point playback position. The byte is sign-magnitude data, and the value 0xFF is reserved as a loop marker. The engine converts the sample to a signed value, scales it by the voice's envelope level and by one pan nibble per side, and adds it into a left sum and a right sum. At the end of the walk, both sums are clamped to 16 bits and presented with a one-cycle valid strobe.

Voice parameters arrive as flat per-voice buses. Each voice has an envelope, a pan byte, a 16-bit frequency step, a 16-bit loop-start address, an 8-bit start page and an enable bit. A global enable applies to all voices. The host decodes its own registers and drives these buses. The wave memory sits outside the block and answers each address one clock after it is presented. The output period is set by `TICK_CYCLES`, which defaults to 1536 clocks.

Top module: `pcm_mixer8`

## Requirements
- R1: While reset is asserted and until the first strobe, `out_l` and `out_r` are 0 and `out_valid` is 0. After reset every playback position is 0.
- R2: `out_valid` is high for exactly one clock. It repeats every `TICK_CYCLES` clocks, and `TICK_CYCLES` must be at least 26.
- R3: A playback position has 27 bits: 16 integer bits above 11 fraction bits. The memory address read for a voice is bits 26:11 of its position. After a non-marker fetch the position grows by the voice's step, modulo 2^27. A step of 0x800 moves one byte per sample, and 0x400 moves half a byte.
- R4: If the fetched byte is 0xFF, the position becomes loop-start × 2^11 and does not advance in that period. The byte at the loop-start address is used in place of the marker.
- R5: If the byte used for a voice is 0xFF, even after the loop reload, that voice adds nothing to either side for that sample.
- R6: Sample byte b has value +b[6:0] when b[7] is 1, and −b[6:0] when b[7] is 0.
- R7: The left contribution of a voice is floor(value × envelope × pan[3:0] / 32). The right contribution uses pan[7:4].
- R8: Each side's sum over the eight voices is clamped to the range −32768 to +32767 before output.
- R9: While a voice's enable bit is 0, that voice adds nothing. Its position is held at start × 2^19, so playback resumes from the start page when the voice is enabled again.
- R10: If the global enable is 0 when a period begins, that period's outputs are 0 and the positions of enabled voices do not move.
- R11: The contributions of all enabled voices are summed into the same output sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mix_on | input | 1 | Global enable, sampled at the start of each period |
| ch_on | input | 8 | Per-voice enable, bit i for voice i |
| ch_env | input | 64 | Envelope level, voice i in bits 8i+7:8i |
| ch_pan | input | 64 | Pan byte, voice i in bits 8i+7:8i; low nibble left, high nibble right |
| ch_start | input | 64 | Start page, voice i in bits 8i+7:8i |
| ch_step | input | 128 | Frequency step (5.11 format), voice i in bits 16i+15:16i |
| ch_loop | input | 128 | Loop-start byte address, voice i in bits 16i+15:16i |
| mem_addr | output | 16 | Wave memory byte address |
| mem_rdata | input | 8 | Wave memory data, valid one clock after `mem_addr` |
| out_l | output | 16 | Signed left sample |
| out_r | output | 16 | Signed right sample |
| out_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench builds the mixer with `TICK_CYCLES` = 32 instead of 1536. Each period still contains the full 24-clock voice walk, and dozens of samples fit in a short run. This makes it practical to step through multi-sample sequences: fractional stepping, marker reloads that repeat the loop byte, the double-marker silence case, and a voice being disabled and re-enabled. The small period also makes the exact strobe spacing cheap to measure.

// File: rtl/pcm_mix_pkg.sv
package pcm_mix_pkg;
    localparam int CH_N      = 8;
    localparam int CH_W      = $clog2(CH_N);
    localparam int INT_W     = 16;
    localparam int FRAC_W    = 11;
    localparam int PA_W      = INT_W + FRAC_W;
    localparam int BYTE_W    = 8;
    localparam int STEP_W    = 16;
    localparam int CONTRIB_W = 16;
    localparam int ACC_W     = CONTRIB_W + CH_W + 1;
    localparam int OUT_W     = 16;
    localparam int START_SH  = PA_W - BYTE_W;
    localparam logic [BYTE_W-1:0] MARKER = 8'hFF;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_MARK  = 2'd1,
        PH_USE   = 2'd2
    } phase_t;
endpackage

// File: rtl/pcm_tick_gen.sv
module pcm_tick_gen #(
    parameter int PERIOD = 1536
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/pcm_voice_scale.sv
module pcm_voice_scale
    import pcm_mix_pkg::*;
(
    input  logic [BYTE_W-1:0]           smp,
    input  logic [BYTE_W-1:0]           env,
    input  logic [BYTE_W-1:0]           pan,
    output logic signed [CONTRIB_W-1:0] con_l,
    output logic signed [CONTRIB_W-1:0] con_r
);
    localparam int PR_W = 7 + BYTE_W + 4;

    logic signed [CONTRIB_W-1:0] side [2];

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic [3:0]      nib;
        logic [PR_W-1:0] prod;
        logic [PR_W:0]   ceil_sum;
        always_comb begin
            nib      = (s == 0) ? pan[3:0] : pan[7:4];
            prod     = PR_W'(smp[6:0]) * PR_W'(env) * PR_W'(nib);
            ceil_sum = {1'b0, prod} + (PR_W+1)'(31);
            if (smp[7]) side[s] = CONTRIB_W'(prod >> 5);
            else        side[s] = -$signed(CONTRIB_W'(ceil_sum >> 5));
        end
    end

    assign con_l = side[0];
    assign con_r = side[1];
endmodule

// File: rtl/pcm_sat.sv
module pcm_sat #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic signed [IN_W-1:0] HI = IN_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] LO = -HI - 1;

    always_comb begin
        if (din > HI)      dout = OUT_W'(HI);
        else if (din < LO) dout = OUT_W'(LO);
        else               dout = OUT_W'(din);
    end
endmodule

// File: rtl/pcm_mixer8.sv
module pcm_mixer8
    import pcm_mix_pkg::*;
#(
    parameter int TICK_CYCLES = 1536
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mix_on,
    input  logic [CH_N-1:0]           ch_on,
    input  logic [CH_N*BYTE_W-1:0]    ch_env,
    input  logic [CH_N*BYTE_W-1:0]    ch_pan,
    input  logic [CH_N*BYTE_W-1:0]    ch_start,
    input  logic [CH_N*STEP_W-1:0]    ch_step,
    input  logic [CH_N*INT_W-1:0]     ch_loop,
    output logic [INT_W-1:0]          mem_addr,
    input  logic [BYTE_W-1:0]         mem_rdata,
    output logic signed [OUT_W-1:0]   out_l,
    output logic signed [OUT_W-1:0]   out_r,
    output logic                      out_valid
);
    typedef struct packed {
        logic                            busy;
        logic                            run;
        logic [CH_W-1:0]                 ch;
        phase_t                          phase;
        logic                            loop_hit;
        logic [BYTE_W-1:0]               hold;
        logic signed [ACC_W-1:0]         acc_l;
        logic signed [ACC_W-1:0]         acc_r;
        logic signed [OUT_W-1:0]         o_l;
        logic signed [OUT_W-1:0]         o_r;
        logic                            valid;
        logic [CH_N-1:0][PA_W-1:0]       addr;
    } mix_st_t;

    mix_st_t st_d, st_q;

    logic                         tick;
    logic [BYTE_W-1:0]            use_byte;
    logic                         voice_live;
    logic signed [CONTRIB_W-1:0]  con_l, con_r;
    logic signed [ACC_W-1:0]      sum_l, sum_r;
    logic signed [OUT_W-1:0]      sat_l, sat_r;
    logic [INT_W-1:0]             cur_loop;
    logic [STEP_W-1:0]            cur_step;

    pcm_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign use_byte   = st_q.loop_hit ? mem_rdata : st_q.hold;
    assign voice_live = st_q.run && ch_on[st_q.ch];
    assign cur_loop   = ch_loop[st_q.ch*INT_W +: INT_W];
    assign cur_step   = ch_step[st_q.ch*STEP_W +: STEP_W];

    pcm_voice_scale u_scale (
        .smp   (use_byte),
        .env   (ch_env[st_q.ch*BYTE_W +: BYTE_W]),
        .pan   (ch_pan[st_q.ch*BYTE_W +: BYTE_W]),
        .con_l (con_l),
        .con_r (con_r)
    );

    always_comb begin
        if (voice_live && (use_byte != MARKER)) begin
            sum_l = st_q.acc_l + ACC_W'(con_l);
            sum_r = st_q.acc_r + ACC_W'(con_r);
        end else begin
            sum_l = st_q.acc_l;
            sum_r = st_q.acc_r;
        end
    end

    pcm_sat #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_sat_l (.din(sum_l), .dout(sat_l));
    pcm_sat #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_sat_r (.din(sum_r), .dout(sat_r));

    // Memory address: the loop-start location is presented speculatively in
    // the marker phase, so the re-read never waits on the fetched byte.
    assign mem_addr = (st_q.phase == PH_MARK) ? cur_loop
                                              : st_q.addr[st_q.ch][PA_W-1:FRAC_W];

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;

        for (int i = 0; i < CH_N; i++) begin
            if (!ch_on[i]) st_d.addr[i] = {ch_start[i*BYTE_W +: BYTE_W], START_SH'(0)};
        end

        if (!st_q.busy) begin
            if (tick) begin
                st_d.busy  = 1'b1;
                st_d.run   = mix_on;
                st_d.ch    = '0;
                st_d.phase = PH_FETCH;
                st_d.acc_l = '0;
                st_d.acc_r = '0;
            end
        end else begin
            unique case (st_q.phase)
                PH_FETCH: st_d.phase = PH_MARK;
                PH_MARK: begin
                    if (voice_live) begin
                        if (mem_rdata == MARKER) begin
                            st_d.addr[st_q.ch] = {cur_loop, FRAC_W'(0)};
                            st_d.loop_hit      = 1'b1;
                        end else begin
                            st_d.addr[st_q.ch] = st_q.addr[st_q.ch] + PA_W'(cur_step);
                            st_d.loop_hit      = 1'b0;
                            st_d.hold          = mem_rdata;
                        end
                    end
                    st_d.phase = PH_USE;
                end
                PH_USE: begin
                    st_d.acc_l = sum_l;
                    st_d.acc_r = sum_r;
                    st_d.phase = PH_FETCH;
                    if (st_q.ch == CH_W'(CH_N - 1)) begin
                        st_d.busy  = 1'b0;
                        st_d.valid = 1'b1;
                        st_d.o_l   = sat_l;
                        st_d.o_r   = sat_r;
                    end else begin
                        st_d.ch = st_q.ch + 1'b1;
                    end
                end
                default: st_d.phase = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_l     = st_q.o_l;
    assign out_r     = st_q.o_r;
    assign out_valid = st_q.valid;

    logic                      run_view;
    logic [CH_N*PA_W-1:0]      addr_view;
    assign run_view  = st_q.run;
    assign addr_view = st_q.addr;
endmodule

// File: rtl/pcm_mixer8_chk.sv
module pcm_mixer8_chk
    import pcm_mix_pkg::*;
#(
    parameter int TICK_CYCLES = 1536
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     out_valid,
    input logic signed [OUT_W-1:0]  out_l,
    input logic signed [OUT_W-1:0]  out_r,
    input logic                     run_view,
    input logic [CH_N-1:0]          ch_on,
    input logic [CH_N*BYTE_W-1:0]   ch_start,
    input logic [CH_N*PA_W-1:0]     addr_view
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (out_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2
    strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (gap_q == 32'(TICK_CYCLES - 1)));

    // R10
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !run_view) |-> (out_l == '0 && out_r == '0));

    for (genvar i = 0; i < CH_N; i++) begin : g_voice
        // R9
        off_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_on[i] |=> (addr_view[i*PA_W +: PA_W] ==
                           {$past(ch_start[i*BYTE_W +: BYTE_W]), START_SH'(0)}));
    end
endmodule

bind pcm_mixer8 pcm_mixer8_chk #(.TICK_CYCLES(TICK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_l     (out_l),
    .out_r     (out_r),
    .run_view  (run_view),
    .ch_on     (ch_on),
    .ch_start  (ch_start),
    .addr_view (addr_view)
);

// File: tb/tb_pcm_mixer8.sv
module tb_pcm_mixer8;
    localparam int TICK = 32;
    localparam int MEM_N = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              mix_on;
    logic [7:0]        on;
    logic [7:0]        env   [8];
    logic [7:0]        pan   [8];
    logic [7:0]        start [8];
    logic [15:0]       step  [8];
    logic [15:0]       loopa [8];
    logic [63:0]       env_f, pan_f, start_f;
    logic [127:0]      step_f, loop_f;
    logic [15:0]       mem_addr;
    logic [7:0]        mem_rdata;
    logic signed [15:0] out_l, out_r;
    logic              out_valid;
    logic [7:0]        mem [MEM_N];

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            env_f[i*8 +: 8]    = env[i];
            pan_f[i*8 +: 8]    = pan[i];
            start_f[i*8 +: 8]  = start[i];
            step_f[i*16 +: 16] = step[i];
            loop_f[i*16 +: 16] = loopa[i];
        end
    end

    always_ff @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

    pcm_mixer8 #(.TICK_CYCLES(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .mix_on(mix_on), .ch_on(on),
        .ch_env(env_f), .ch_pan(pan_f), .ch_start(start_f),
        .ch_step(step_f), .ch_loop(loop_f),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [26:0] maddr [8];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent reference: one output sample from the requirements.
    task automatic model_sample(output int el, output int er);
        el = 0;
        er = 0;
        for (int j = 0; j < 8; j++)
            if (!on[j]) maddr[j] = {start[j], 19'b0};
        if (mix_on) begin
            for (int j = 0; j < 8; j++) begin
                if (on[j]) begin
                    logic [7:0] b;
                    int s;
                    b = mem[maddr[j][20:11]];
                    if (b == 8'hFF) begin
                        maddr[j] = {loopa[j], 11'b0};
                        b = mem[loopa[j][9:0]];
                    end else begin
                        maddr[j] = maddr[j] + {11'b0, step[j]};
                    end
                    if (b != 8'hFF) begin
                        s = b[7] ? int'(b[6:0]) : -int'(b[6:0]);
                        el += (s * int'(env[j]) * int'(pan[j][3:0])) >>> 5;
                        er += (s * int'(env[j]) * int'(pan[j][7:4])) >>> 5;
                    end
                end
            end
        end
        if (el > 32767) el = 32767;
        if (el < -32768) el = -32768;
        if (er > 32767) er = 32767;
        if (er < -32768) er = -32768;
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!out_valid);
    endtask

    task automatic expect_samples(int n, string req);
        for (int k = 0; k < n; k++) begin
            int el, er;
            wait_valid();
            model_sample(el, er);
            check(req, int'(out_l), el);
            check(req, int'(out_r), er);
        end
    endtask

    task automatic all_off();
        on = '0;
        for (int i = 0; i < 8; i++) begin
            env[i] = 8'h00; pan[i] = 8'h00; start[i] = 8'h00;
            step[i] = 16'h0000; loopa[i] = 16'h0000;
        end
    endtask

    task automatic t_reset();
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 left in reset", int'(out_l), 0);
        check("R1 right in reset", int'(out_r), 0);
        @(negedge clk);
        rst_n = 1'b1;
        expect_samples(1, "R1 first sample");
    endtask

    task automatic t_period();
        int gap = 0;
        wait_valid();
        model_sample(gap, gap);
        gap = 0;
        @(negedge clk);
        check("R2 strobe width", int'(out_valid), 0);
        gap = 1;
        while (!out_valid) begin
            @(negedge clk);
            gap++;
        end
        check("R2 strobe period", gap, TICK);
        begin int el, er; model_sample(el, er); end
    endtask

    task automatic t_basic();
        mem[0] = 8'h85; mem[1] = 8'h05; mem[2] = 8'h80; mem[3] = 8'hFE;
        mem[4] = 8'h7F; mem[5] = 8'h01; mem[6] = 8'h00; mem[7] = 8'hC3;
        env[0] = 8'h41; pan[0] = 8'h3F; step[0] = 16'h0800; start[0] = 8'h00;
        expect_samples(1, "R9 arm");
        on[0] = 1'b1;
        expect_samples(8, "R6 R7 R3 sign and scale");
    endtask

    task automatic t_frac();
        on = '0;
        for (int i = 0; i < 6; i++) mem[256 + i] = 8'h90 + 8'(i * 3);
        env[1] = 8'h20; pan[1] = 8'hA5; step[1] = 16'h0400; start[1] = 8'h01;
        expect_samples(1, "R9 arm");
        on[1] = 1'b1;
        expect_samples(8, "R3 fractional step");
    endtask

    task automatic t_loop();
        on = '0;
        mem[512] = 8'h88; mem[513] = 8'h10; mem[514] = 8'hA0; mem[515] = 8'h22;
        mem[516] = 8'hFF; mem[528] = 8'hC0; mem[529] = 8'h81; mem[530] = 8'hFF;
        mem[768] = 8'hFF;
        env[2] = 8'h7F; pan[2] = 8'h9C; step[2] = 16'h0800; start[2] = 8'h02;
        loopa[2] = 16'd528;
        env[3] = 8'hFF; pan[3] = 8'hFF; step[3] = 16'h0800; start[3] = 8'h03;
        loopa[3] = 16'd768;
        expect_samples(1, "R9 arm");
        on[3] = 1'b1;
        expect_samples(3, "R5 double marker silent");
        on[2] = 1'b1;
        expect_samples(12, "R4 marker reload");
    endtask

    task automatic t_sat();
        all_off();
        mem[0] = 8'hFE;
        for (int i = 0; i < 8; i++) begin
            env[i] = 8'h10; pan[i] = 8'hF7;
        end
        expect_samples(1, "R9 arm");
        on = 8'hFF;
        expect_samples(2, "R11 eight voices summed");
        for (int i = 0; i < 8; i++) env[i] = 8'hFF;
        expect_samples(2, "R8 positive clamp");
        mem[0] = 8'h7F;
        expect_samples(2, "R8 negative clamp");
    endtask

    task automatic t_chan_off();
        all_off();
        for (int i = 0; i < 4; i++) mem[i] = 8'hA0 + 8'(i);
        env[0] = 8'h30; pan[0] = 8'h44; step[0] = 16'h0800;
        env[4] = 8'h30; pan[4] = 8'h44; step[4] = 16'h0800;
        expect_samples(1, "R9 arm");
        on[0] = 1'b1; on[4] = 1'b1;
        expect_samples(3, "R9 two voices");
        on[4] = 1'b0;
        expect_samples(2, "R9 voice disabled");
        on[4] = 1'b1;
        expect_samples(3, "R9 restart from start page");
    endtask

    task automatic t_global();
        mix_on = 1'b0;
        expect_samples(3, "R10 global off");
        mix_on = 1'b1;
        expect_samples(3, "R10 resume without skip");
    endtask

    initial begin
        mix_on = 1'b1;
        all_off();
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) maddr[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_period();
        t_basic();
        t_frac();
        t_loop();
        t_sat();
        t_chan_off();
        t_global();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule